// File: doc/BRIEF.md
# Scheduler Queue Steering Dispatcher

This block sits between two in-order micro-operation queues and five scheduler queues. The address queue holds only load-address and store-address uops. The general queue holds all other uops. Each clock the dispatcher looks at up to two head uops from each source queue. It tells each source how many of those uops it accepted, and it writes the accepted uops into the matching scheduler queue. The five scheduler queues are two fast integer queues (FAST_0, FAST_1), two slow queues (SLOW_0, SLOW_1) and the memory queue (MEM).

Every general uop carries a 4-bit operation class, and the class decides its destination. One class, simple moves and simple arithmetic, may run on either fast scheduler. For that class the dispatcher picks the less occupied of the two fast queues. A source queue is served strictly in order: if its head uop cannot be placed, nothing behind it moves. The two sources are steered in the same cycle, and neither blocks the other. Each scheduler queue is a FIFO with an occupancy output. Its head is popped by a per-queue drain input that stands in for the scheduler.

Top module: `sst_dispatch`

## Requirements
- R1: While reset is low and after it is released, every scheduler queue count is zero and every head-valid output is low.
- R2: Every accepted address-queue uop enters the MEM queue. MEM queue index is 4, and the class of an address uop is not consulted.
- R3: General classes with a single destination map as follows: 0 logical, 1 branch, 2 integer store-data and 4 sign-extend/negate go to FAST_0 (index 0). 5 FP/SIMD move-convert and 6 FP store-data go to SLOW_0 (index 2). 7 shift/rotate, 8 carry-based add/sub, 9 multiply/complex and 10 FP compute go to SLOW_1 (index 3).
- R4: Class 3 (simple move/lea/add/sub/cmp/inc/dec) goes to whichever of FAST_0 and FAST_1 (index 1) holds fewer entries, with ties going to FAST_0. Slot 1 sees the occupancy as already raised by a slot-0 uop accepted in the same cycle.
- R5: A general uop never enters the MEM queue, and an address uop never enters any other queue.
- R6: The take outputs (bit 0 is the head, bit 1 the next uop) are in order. Slot 1 is taken only when slot 0 is taken and slot 1 is valid. A slot-0 uop that cannot be placed stops its whole source queue for that cycle.
- R7: A queue whose count equals DEPTH at the start of a cycle accepts no write in that cycle, even if it is drained in that cycle. The stalled uop is taken in the first cycle that starts with a free entry.
- R8: At most two uops enter any scheduler queue per clock. The address source gets two uops accepted when MEM has at least two free entries, and only its head when MEM has exactly one.
- R9: Each scheduler queue delivers uops in arrival order, and slot 0 arrives before slot 1 within a cycle.
- R10: A drain pops the head when the queue is non-empty and is ignored when it is empty. The next count equals the current count plus writes minus pops.
- R11: Reserved class codes 11 to 15 are steered to FAST_0.
- R12: A full MEM queue stalls only the address source. General uops keep flowing in the same cycles, and a full general-side queue does not stop the address source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aq_valid | input | 2 | Address source: valid for head (bit 0) and next (bit 1) |
| aq_tag | input | 2*TW | Address source uop tags, slot 0 in low bits |
| aq_take | output | 2 | Address source uops accepted this cycle |
| gq_valid | input | 2 | General source: valid for head (bit 0) and next (bit 1) |
| gq_cls | input | 8 | General source operation classes, 4 bits per slot |
| gq_tag | input | 2*TW | General source uop tags, slot 0 in low bits |
| gq_take | output | 2 | General source uops accepted this cycle |
| sq_drain | input | 5 | Per scheduler queue pop request (0 FAST_0, 1 FAST_1, 2 SLOW_0, 3 SLOW_1, 4 MEM) |
| sq_head_valid | output | 5 | Per scheduler queue non-empty |
| sq_head_tag | output | 5*TW | Per scheduler queue head tag |
| sq_count | output | 5*OW | Per scheduler queue occupancy, OW = clog2(DEPTH+1) |

## Verification
The bench fills SLOW_1 to capacity and then offers a blocked head with a placeable uop behind it. A design that skipped over the blocked head would reorder the source and would report take 10 where 00 is expected. It also fills MEM to one free entry while two address uops are offered. A design that counted free space wrongly would overfill MEM or accept none, and general traffic offered in those same cycles shows whether a MEM stall leaks into the general source. Pairs of class-3 uops check the tie rule and the in-cycle occupancy adjustment: a design that ignored the slot-0 placement would send both uops to FAST_0. A long run with random classes and random drains checks every queue's order and count, which exposes any misrouted class or any pop of an empty queue.

// File: rtl/sst_pkg.sv
// Shared definitions for the scheduler steering dispatcher.
// Assumes general-side queue indices 0..3 and MEM at index 4.
package sst_pkg;
    localparam int NQ   = 5;
    localparam int CLSW = 4;
    localparam int QMEM = 4;

    typedef enum logic [CLSW-1:0] {
        UC_LOGIC    = 4'd0,
        UC_BRANCH   = 4'd1,
        UC_ISTD     = 4'd2,
        UC_ALU_DUAL = 4'd3,
        UC_SEXT_NEG = 4'd4,
        UC_FPMOVE   = 4'd5,
        UC_FPSTD    = 4'd6,
        UC_SHIFT    = 4'd7,
        UC_CARRY    = 4'd8,
        UC_CPLX     = 4'd9,
        UC_FPCALC   = 4'd10
    } uclass_e;

    // Eligibility mask over the four general-side queues {S1,S0,F1,F0}.
    function automatic logic [3:0] elig(input logic [CLSW-1:0] c);
        case (uclass_e'(c))
            UC_ALU_DUAL:                         return 4'b0011;
            UC_FPMOVE, UC_FPSTD:                 return 4'b0100;
            UC_SHIFT, UC_CARRY, UC_CPLX, UC_FPCALC: return 4'b1000;
            default:                             return 4'b0001;
        endcase
    endfunction
endpackage

// File: rtl/sst_steer.sv
// General-source steering: picks a destination for each of two head uops
// and decides how many are accepted. Assumes occupancy is sampled at the
// start of the cycle; pops in the same cycle do not create space.
module sst_steer #(
    parameter int DEPTH = 12,
    parameter int OW    = 4
) (
    input  logic [1:0]      valid_i,
    input  logic [7:0]      cls_i,
    input  logic [4*OW-1:0] occ_i,
    output logic [1:0]      take_o,
    output logic [1:0]      tgt0_o,
    output logic [1:0]      tgt1_o
);
    logic [OW-1:0] occ0 [4];
    logic [OW-1:0] occ1 [4];
    logic [3:0]    m0, m1;
    logic          ok0, ok1;

    // Choose a queue index from an eligibility mask and fast-queue occupancy.
    function automatic logic [1:0] pick(input logic [3:0] m,
                                        input logic [OW-1:0] f0,
                                        input logic [OW-1:0] f1);
        if (m[0] && m[1]) return (f1 < f0) ? 2'd1 : 2'd0;
        if (m[3])         return 2'd3;
        if (m[2])         return 2'd2;
        if (m[1])         return 2'd1;
        return 2'd0;
    endfunction

    // Slot 0 choice and space test against start-of-cycle occupancy.
    always_comb begin
        for (int q = 0; q < 4; q++) occ0[q] = occ_i[q*OW +: OW];
        m0     = sst_pkg::elig(cls_i[3:0]);
        tgt0_o = pick(m0, occ0[0], occ0[1]);
        ok0    = valid_i[0] && (occ0[tgt0_o] < OW'(DEPTH));
    end

    // Slot 1 choice against occupancy raised by an accepted slot 0.
    always_comb begin
        for (int q = 0; q < 4; q++)
            occ1[q] = occ0[q] + OW'(ok0 && (tgt0_o == 2'(q)));
        m1     = sst_pkg::elig(cls_i[7:4]);
        tgt1_o = pick(m1, occ1[0], occ1[1]);
        ok1    = ok0 && valid_i[1] && (occ1[tgt1_o] < OW'(DEPTH));
    end

    assign take_o = {ok1, ok0};
endmodule

// File: rtl/sst_schq.sv
// Scheduler queue model: FIFO of DEPTH entries with two ordered write ports
// and one pop port. Assumes the writer never exceeds the free space.
module sst_schq #(
    parameter int DEPTH = 12,
    parameter int TW    = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wa_en,
    input  logic [TW-1:0]              wa_data,
    input  logic                       wb_en,
    input  logic [TW-1:0]              wb_data,
    input  logic                       rd_en,
    output logic                       head_valid,
    output logic [TW-1:0]              head_data,
    output logic [$clog2(DEPTH+1)-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OW = $clog2(DEPTH+1);

    logic [TW-1:0] mem [DEPTH];
    logic [PW-1:0] wp, rp, wp_nx;
    logic          one_wr, two_wr, pop;
    logic [TW-1:0] first_d;

    // Advance a pointer with wrap at DEPTH.
    function automatic logic [PW-1:0] adv(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    assign two_wr     = wa_en & wb_en;
    assign one_wr     = wa_en ^ wb_en;
    assign first_d    = wa_en ? wa_data : wb_data;
    assign wp_nx      = adv(wp);
    assign head_valid = (count != '0);
    assign pop        = rd_en && head_valid;
    assign head_data  = mem[rp];

    // Store up to two entries in arrival order.
    always_ff @(posedge clk) begin
        if (one_wr || two_wr) mem[wp]    <= first_d;
        if (two_wr)           mem[wp_nx] <= wb_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (two_wr)      wp <= adv(wp_nx);
            else if (one_wr) wp <= wp_nx;
            if (pop)         rp <= adv(rp);
            count <= count + OW'(two_wr ? 2 : (one_wr ? 1 : 0)) - OW'(pop);
        end
    end
endmodule

// File: rtl/sst_dispatch.sv
// Top of the steering dispatcher. Address uops always go to MEM; general
// uops are steered by class through sst_steer. Five sst_schq instances
// model the scheduler queues. Assumes source slot 0 is older than slot 1.
module sst_dispatch #(
    parameter int DEPTH = 12,
    parameter int TW    = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         aq_valid,
    input  logic [2*TW-1:0]                    aq_tag,
    output logic [1:0]                         aq_take,
    input  logic [1:0]                         gq_valid,
    input  logic [7:0]                         gq_cls,
    input  logic [2*TW-1:0]                    gq_tag,
    output logic [1:0]                         gq_take,
    input  logic [4:0]                         sq_drain,
    output logic [4:0]                         sq_head_valid,
    output logic [5*TW-1:0]                    sq_head_tag,
    output logic [5*$clog2(DEPTH+1)-1:0]       sq_count
);
    localparam int OW = $clog2(DEPTH+1);
    localparam int NQ = sst_pkg::NQ;

    logic [OW-1:0]  mem_occ;
    logic [1:0]     tgt0, tgt1;
    logic [NQ-1:0]  wa_en, wb_en;
    logic [TW-1:0]  wa_d [NQ];
    logic [TW-1:0]  wb_d [NQ];

    assign mem_occ = sq_count[sst_pkg::QMEM*OW +: OW];

    // Address source acceptance against MEM free space.
    always_comb begin
        aq_take[0] = aq_valid[0] && (int'(mem_occ) < DEPTH);
        aq_take[1] = aq_take[0] && aq_valid[1] && (int'(mem_occ) + 1 < DEPTH);
    end

    sst_steer #(.DEPTH(DEPTH), .OW(OW)) u_steer (
        .valid_i (gq_valid),
        .cls_i   (gq_cls),
        .occ_i   (sq_count[4*OW-1:0]),
        .take_o  (gq_take),
        .tgt0_o  (tgt0),
        .tgt1_o  (tgt1)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_q
        if (q == sst_pkg::QMEM) begin : g_mem
            // MEM queue is written only by the address source.
            assign wa_en[q] = aq_take[0];
            assign wb_en[q] = aq_take[1];
            assign wa_d[q]  = aq_tag[TW-1:0];
            assign wb_d[q]  = aq_tag[2*TW-1:TW];
        end else begin : g_gen
            // General queues are written by the steered general slots.
            assign wa_en[q] = gq_take[0] && (tgt0 == 2'(q));
            assign wb_en[q] = gq_take[1] && (tgt1 == 2'(q));
            assign wa_d[q]  = gq_tag[TW-1:0];
            assign wb_d[q]  = gq_tag[2*TW-1:TW];
        end

        sst_schq #(.DEPTH(DEPTH), .TW(TW)) u_q (
            .clk        (clk),
            .rst_n      (rst_n),
            .wa_en      (wa_en[q]),
            .wa_data    (wa_d[q]),
            .wb_en      (wb_en[q]),
            .wb_data    (wb_d[q]),
            .rd_en      (sq_drain[q]),
            .head_valid (sq_head_valid[q]),
            .head_data  (sq_head_tag[q*TW +: TW]),
            .count      (sq_count[q*OW +: OW])
        );
    end
endmodule

// File: rtl/sst_dispatch_chk.sv
// Port-level checker for sst_dispatch, attached by bind below.
module sst_dispatch_chk #(
    parameter int DEPTH = 12,
    parameter int TW    = 8
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [1:0]                   aq_valid,
    input logic [1:0]                   aq_take,
    input logic [1:0]                   gq_valid,
    input logic [1:0]                   gq_take,
    input logic                         mem_drain,
    input logic [4:0]                   sq_head_valid,
    input logic [5*$clog2(DEPTH+1)-1:0] sq_count
);
    localparam int OW = $clog2(DEPTH+1);

    logic [OW-1:0] mem_cnt;
    assign mem_cnt = sq_count[4*OW +: OW];

    for (genvar q = 0; q < 5; q++) begin : g_q
        p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
            int'(sq_count[q*OW +: OW]) <= DEPTH);
        p_head_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
            sq_head_valid[q] == (sq_count[q*OW +: OW] != '0));
    end

    p_aq_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        aq_take[1] |-> aq_take[0]);
    p_gq_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
        gq_take[1] |-> gq_take[0]);
    p_aq_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (aq_take[0] |-> aq_valid[0]) and (aq_take[1] |-> aq_valid[1]));
    p_gq_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (gq_take[0] |-> gq_valid[0]) and (gq_take[1] |-> gq_valid[1]));
    p_mem_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(mem_cnt) == DEPTH) |-> (aq_take == 2'b00));
    p_mem_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(mem_cnt) + 2 <= DEPTH) && (aq_valid == 2'b11)) |-> (aq_take == 2'b11));
    p_mem_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> int'(mem_cnt) == int'($past(mem_cnt))
            + int'($past(aq_take[0])) + int'($past(aq_take[1]))
            - int'($past(mem_drain && sq_head_valid[4])));
endmodule

bind sst_dispatch sst_dispatch_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .aq_valid      (aq_valid),
    .aq_take       (aq_take),
    .gq_valid      (gq_valid),
    .gq_take       (gq_take),
    .mem_drain     (sq_drain[4]),
    .sq_head_valid (sq_head_valid),
    .sq_count      (sq_count)
);

// File: tb/sst_dispatch_tb.sv
`timescale 1ns/1ps
module sst_dispatch_tb;
    localparam int DEPTH = 12;
    localparam int TW    = 8;
    localparam int OW    = $clog2(DEPTH+1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        aq_valid = '0;
    logic [2*TW-1:0]   aq_tag = '0;
    logic [1:0]        aq_take;
    logic [1:0]        gq_valid = '0;
    logic [7:0]        gq_cls = '0;
    logic [2*TW-1:0]   gq_tag = '0;
    logic [1:0]        gq_take;
    logic [4:0]        sq_drain = '0;
    logic [4:0]        sq_head_valid;
    logic [5*TW-1:0]   sq_head_tag;
    logic [5*OW-1:0]   sq_count;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    int mcnt [5];
    int expq [5][$];
    int tagc = 0;

    always #5 clk = ~clk;

    sst_dispatch #(.DEPTH(DEPTH), .TW(TW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .aq_valid(aq_valid), .aq_tag(aq_tag), .aq_take(aq_take),
        .gq_valid(gq_valid), .gq_cls(gq_cls), .gq_tag(gq_tag), .gq_take(gq_take),
        .sq_drain(sq_drain), .sq_head_valid(sq_head_valid),
        .sq_head_tag(sq_head_tag), .sq_count(sq_count)
    );

    task automatic chk(input string lab, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", lab, act, exp);
        end
    endtask

    // Destination from the class table in the requirements.
    function automatic int dest(input int c, input int o0, input int o1);
        if (c == 3) return (o1 < o0) ? 1 : 0;
        if (c == 5 || c == 6) return 2;
        if (c >= 7 && c <= 10) return 3;
        return 0;
    endfunction

    // Driver plus scoreboard for one cycle: predict, compare, update model.
    task automatic step(input logic [1:0] av, input logic [1:0] gv,
                        input int c0, input int c1, input logic [4:0] dr,
                        input string lab);
        int t0, t1, a0, a1, g0, g1;
        bit p0, p1, k0, k1;
        int o [4];
        @(negedge clk);
        a0 = tagc & 255; a1 = (tagc + 1) & 255;
        g0 = (tagc + 2) & 255; g1 = (tagc + 3) & 255;
        tagc += 4;
        aq_valid = av; aq_tag = {a1[TW-1:0], a0[TW-1:0]};
        gq_valid = gv; gq_tag = {g1[TW-1:0], g0[TW-1:0]};
        gq_cls   = {c1[3:0], c0[3:0]};
        sq_drain = dr;
        #1;
        for (int q = 0; q < 5; q++) begin
            chk({lab, " count"}, int'(sq_count[q*OW +: OW]), mcnt[q]);
            chk({lab, " head_valid"}, int'(sq_head_valid[q]), int'(mcnt[q] > 0));
        end
        p0 = av[0] && (mcnt[4] < DEPTH);
        p1 = p0 && av[1] && (mcnt[4] + 1 < DEPTH);
        chk({lab, " aq_take"}, int'(aq_take), int'({p1, p0}));
        for (int q = 0; q < 4; q++) o[q] = mcnt[q];
        t0 = dest(c0, o[0], o[1]);
        k0 = gv[0] && (o[t0] < DEPTH);
        if (k0) o[t0]++;
        t1 = dest(c1, o[0], o[1]);
        k1 = k0 && gv[1] && (o[t1] < DEPTH);
        chk({lab, " gq_take"}, int'(gq_take), int'({k1, k0}));
        for (int q = 0; q < 5; q++) begin
            if (dr[q] && mcnt[q] > 0) begin
                chk({lab, " head_tag"}, int'(sq_head_tag[q*TW +: TW]), expq[q][0]);
                void'(expq[q].pop_front());
                mcnt[q]--;
            end
        end
        if (p0) begin expq[4].push_back(a0); mcnt[4]++; end
        if (p1) begin expq[4].push_back(a1); mcnt[4]++; end
        if (k0) begin expq[t0].push_back(g0); mcnt[t0]++; end
        if (k1) begin expq[t1].push_back(g1); mcnt[t1]++; end
    endtask

    task automatic drain_all(input string lab);
        for (int i = 0; i < 40; i++) begin
            if (mcnt[0] + mcnt[1] + mcnt[2] + mcnt[3] + mcnt[4] == 0) break;
            step(2'b00, 2'b00, 0, 0, 5'b11111, lab);
        end
    endtask

    initial begin
        for (int q = 0; q < 5; q++) mcnt[q] = 0;
        repeat (3) @(negedge clk);
        // R1: state during reset
        for (int q = 0; q < 5; q++) begin
            chk("R1 count in reset", int'(sq_count[q*OW +: OW]), 0);
            chk("R1 head_valid in reset", int'(sq_head_valid[q]), 0);
        end
        rst_n = 1'b1;
        step(2'b00, 2'b00, 0, 0, 5'b00000, "R1");

        // Single-target classes, then reserved codes, one at a time.
        for (int c = 0; c < 16; c++) begin
            step(2'b00, 2'b01, c, 0, 5'b00000, (c > 10) ? "R11" : (c == 3) ? "R4" : "R3");
            step(2'b00, 2'b00, 0, 0, 5'b11111, (c > 10) ? "R11" : "R3");
        end

        // R4: dual-eligible pairs balance across the fast queues.
        for (int i = 0; i < 3; i++) step(2'b00, 2'b11, 3, 3, 5'b00000, "R4");
        step(2'b00, 2'b11, 0, 0, 5'b00000, "R4");
        step(2'b00, 2'b11, 3, 3, 5'b00000, "R4");
        step(2'b00, 2'b11, 3, 3, 5'b00000, "R4");
        drain_all("R9");

        // R6/R7: fill SLOW_1 and test head-of-line blocking.
        for (int i = 0; i < 6; i++) step(2'b00, 2'b11, 7, 8, 5'b00000, "R7");
        step(2'b00, 2'b11, 9, 0, 5'b00000, "R6");
        step(2'b00, 2'b11, 0, 10, 5'b00000, "R7");
        step(2'b00, 2'b10, 0, 0, 5'b00000, "R6");
        step(2'b11, 2'b11, 7, 0, 5'b01000, "R12");
        step(2'b00, 2'b01, 7, 0, 5'b00000, "R7");
        drain_all("R9");

        // R8/R12: fill MEM to one free entry, then full.
        step(2'b01, 2'b00, 0, 0, 5'b00000, "R8");
        for (int i = 0; i < 5; i++) step(2'b11, 2'b01, 5, 0, 5'b00000, "R2");
        step(2'b11, 2'b11, 1, 6, 5'b00000, "R8");
        step(2'b11, 2'b11, 2, 4, 5'b00000, "R12");
        step(2'b11, 2'b00, 0, 0, 5'b10000, "R7");
        step(2'b11, 2'b00, 0, 0, 5'b00000, "R7");
        drain_all("R2");

        // R10: drain on empty queues is ignored.
        step(2'b00, 2'b00, 0, 0, 5'b11111, "R10");
        step(2'b00, 2'b00, 0, 0, 5'b00000, "R10");

        // Mixed traffic with random classes and drains.
        for (int i = 0; i < 3000; i++) begin
            step(2'($urandom_range(0, 3)), 2'($urandom_range(0, 3)),
                 int'($urandom_range(0, 15)), int'($urandom_range(0, 15)),
                 5'($urandom_range(0, 31)), "R9");
        end
        drain_all("R5");
        step(2'b00, 2'b00, 0, 0, 5'b00000, "R5");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule